// File: doc/BRIEF.md
# Power and Command Sequencer

This block sits between a serial command receiver and a playback engine in a speech-output device. It moves the device between an unpowered state, a warm-up phase, an optional rising output ramp, an idle state that waits for commands, and two ways of shutting down. It also decides, state by state, whether each decoded command is taken or dropped. Two active-low status lines report progress. `ncr_n` is low while the block cannot take a command. `busy_n` is low while a transition or playback is in progress.

The oscillator and the analog output ramp lie outside this block. Here they appear only as an enable level and two ramp-request levels. Every hold time is a cycle count of the system clock, set by a parameter. At a 4.096 MHz clock the defaults give about 2 ms of stabilisation and about 64 ms for each ramp. The 2-bit field of an accepted power-up command is latched as the memory bank mode. Ordinary commands taken in the idle state are passed on to the playback side as a one-cycle pulse.

States: `PS_OFF` (powered down), `PS_STAB` (oscillator settling), `PS_RAMP_UP` (output rising), `PS_IDLE` (awaiting command), `PS_ACK` (short command acknowledge), `PS_PD_FAST` (instant shutdown), `PS_RAMP_DN` (output falling).

Transitions:
- OFF→STAB on a power-up command.
- STAB→RAMP_UP when the settle time ends after a soft power-up.
- STAB→IDLE when the settle time ends after an instant power-up.
- RAMP_UP→IDLE when the ramp ends.
- IDLE→ACK on an ordinary command.
- ACK→IDLE when the acknowledge time ends.
- IDLE→PD_FAST on an instant power-down while not playing.
- IDLE→RAMP_DN on a soft power-down while not playing.
- PD_FAST→OFF and RAMP_DN→OFF when their times end.
- Any state→OFF on reset.

Top module: `pwr_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the block is powered down. In that state `ncr_n`=1, `busy_n`=1, `osc_en`=0, `ramp_up`=0, `ramp_dn`=0, `cmd_fwd`=0 and `bank_mode`=00.
- R2: While powered down, every opcode except 0 and 1 is ignored. `ncr_n` and `osc_en` do not change.
- R3: Opcode 0 (instant power-up), taken while powered down, holds `ncr_n` and `busy_n` low for exactly STAB_CYC cycles. `osc_en` is high over that time. The block then enters idle with both lines high.
- R4: Opcode 1 (soft power-up), taken while powered down, holds both lines low for exactly STAB_CYC+RAMP_CYC cycles. `ramp_up` is high during the last RAMP_CYC of them.
- R5: Opcode 2 (instant power-down), taken in idle, holds both lines low for exactly PDF_CYC cycles. The block then powers down with `osc_en`=0.
- R6: Opcode 3 (soft power-down), taken in idle, holds both lines low for exactly RAMP_CYC cycles with `ramp_dn` high. The block then powers down.
- R7: Opcodes 2 and 3 are ignored while `playing` is high.
- R8: Any command that arrives during stabilisation, a ramp, an instant power-down or an acknowledge is ignored. The time spent in that phase is unchanged.
- R9: An opcode from 4 to 15 taken in idle holds `ncr_n` low for exactly ACK_CYC cycles. It raises `cmd_fwd` for one cycle, starting the cycle after acceptance, with `fwd_op`/`fwd_arg` equal to the command.
- R10: `cmd_arg[1:0]` of an accepted power-up sets `bank_mode` as follows: 00→00 (one area), 01→01 (two areas), 10→10 (four areas), 11→00. `bank_mode` changes at no other time except reset.
- R11: `rst_n` low forces the powered-down state and its outputs at once, from any state.
- R12: Opcodes 0 and 1 received in idle are ignored.
- R13: In idle and acknowledge, `busy_n` equals the inverse of `playing`. While powered down it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 4 | Command opcode (upper nibble of the command byte) |
| cmd_arg | input | 4 | Command argument (lower nibble) |
| playing | input | 1 | High while the playback engine is producing sound |
| ncr_n | output | 1 | Low while commands cannot be accepted |
| busy_n | output | 1 | Low during transitions or playback |
| osc_en | output | 1 | Oscillator enable |
| ramp_up | output | 1 | Request for a rising output ramp |
| ramp_dn | output | 1 | Request for a falling output ramp |
| bank_mode | output | 2 | Latched bank partitioning mode |
| cmd_fwd | output | 1 | One-cycle pulse for an accepted ordinary command |
| fwd_op | output | 4 | Opcode of the forwarded command |
| fwd_arg | output | 4 | Argument of the forwarded command |

## Verification
The bench builds the block with STAB_CYC=20, RAMP_CYC=40, PDF_CYC=4 and ACK_CYC=3. These short times make every full power cycle a few dozen clocks long, so each low interval on `ncr_n` can be counted exactly. With these values, commands can be injected at chosen points inside the settle phase, the rising and falling ramps, and the acknowledge window, and the bench can confirm that those windows keep their lengths. The same values let a reset land in the middle of a falling ramp and let every bank code be tried across several power-up cycles.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_STAB,
        PS_RAMP_UP,
        PS_IDLE,
        PS_ACK,
        PS_PD_FAST,
        PS_RAMP_DN
    } pwr_state_e;

    typedef enum logic [1:0] {
        BANK_ONE  = 2'b00,
        BANK_TWO  = 2'b01,
        BANK_FOUR = 2'b10
    } bank_mode_e;

    localparam logic [3:0] OP_UP_FAST = 4'd0;
    localparam logic [3:0] OP_UP_SOFT = 4'd1;
    localparam logic [3:0] OP_DN_FAST = 4'd2;
    localparam logic [3:0] OP_DN_SOFT = 4'd3;

    function automatic logic is_power_up(input logic [3:0] op);
        return (op == OP_UP_FAST) || (op == OP_UP_SOFT);
    endfunction

    function automatic logic is_power_down(input logic [3:0] op);
        return (op == OP_DN_FAST) || (op == OP_DN_SOFT);
    endfunction

    // The reserved code 11 falls back to a single area.
    function automatic bank_mode_e decode_bank(input logic [1:0] field);
        bank_mode_e m;
        unique case (field)
            2'b01:   m = BANK_TWO;
            2'b10:   m = BANK_FOUR;
            default: m = BANK_ONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pwr_dwell_timer.sv
module pwr_dwell_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)) // R8
        else $error("timer skipped a step");

endmodule

// File: rtl/pwr_bank_latch.sv
module pwr_bank_latch
    import pwr_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic [1:0] field,
    output logic [1:0] bank_mode
);

    bank_mode_e mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= BANK_ONE;
        end else if (capture) begin
            mode_q <= decode_bank(field);
        end
    end

    assign bank_mode = mode_q;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(bank_mode)) // R10
        else $error("bank mode moved without a power-up");

    AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        bank_mode != 2'b11) // R10
        else $error("reserved bank code latched");

endmodule

// File: rtl/pwr_cmd_ctrl.sv
module pwr_cmd_ctrl
    import pwr_cmd_pkg::*;
#(
    parameter int STAB_CYC = 8192,
    parameter int RAMP_CYC = 262144,
    parameter int PDF_CYC  = 16,
    parameter int ACK_CYC  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic [3:0] cmd_arg,
    input  logic       playing,
    output logic       ncr_n,
    output logic       busy_n,
    output logic       osc_en,
    output logic       ramp_up,
    output logic       ramp_dn,
    output logic [1:0] bank_mode,
    output logic       cmd_fwd,
    output logic [3:0] fwd_op,
    output logic [3:0] fwd_arg
);

    localparam int MAX_A = (STAB_CYC > RAMP_CYC) ? STAB_CYC : RAMP_CYC;
    localparam int MAX_B = (PDF_CYC > ACK_CYC) ? PDF_CYC : ACK_CYC;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_D + 1);

    localparam logic [CW-1:0] STAB_LD = CW'(STAB_CYC - 1);
    localparam logic [CW-1:0] RAMP_LD = CW'(RAMP_CYC - 1);
    localparam logic [CW-1:0] PDF_LD  = CW'(PDF_CYC - 1);
    localparam logic [CW-1:0] ACK_LD  = CW'(ACK_CYC - 1);

    pwr_state_e    st_q, st_nxt;
    logic          soft_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          take_up;
    logic          take_ord;
    logic          fwd_q;
    logic [3:0]    fwd_op_q;
    logic [3:0]    fwd_arg_q;

    pwr_dwell_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pwr_bank_latch u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (take_up),
        .field     (cmd_arg[1:0]),
        .bank_mode (bank_mode)
    );

    // Next-state and command acceptance
    always_comb begin
        st_nxt   = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take_up  = 1'b0;
        take_ord = 1'b0;
        unique case (st_q)
            PS_OFF: begin
                if (cmd_valid && is_power_up(cmd_op)) begin
                    st_nxt   = PS_STAB;
                    tmr_load = 1'b1;
                    tmr_val  = STAB_LD;
                    take_up  = 1'b1;
                end
            end
            PS_STAB: begin
                if (tmr_done) begin
                    if (soft_q) begin
                        st_nxt   = PS_RAMP_UP;
                        tmr_load = 1'b1;
                        tmr_val  = RAMP_LD;
                    end else begin
                        st_nxt = PS_IDLE;
                    end
                end
            end
            PS_RAMP_UP: begin
                if (tmr_done) st_nxt = PS_IDLE;
            end
            PS_IDLE: begin
                if (cmd_valid) begin
                    if (is_power_down(cmd_op)) begin
                        if (!playing) begin
                            tmr_load = 1'b1;
                            if (cmd_op == OP_DN_FAST) begin
                                st_nxt  = PS_PD_FAST;
                                tmr_val = PDF_LD;
                            end else begin
                                st_nxt  = PS_RAMP_DN;
                                tmr_val = RAMP_LD;
                            end
                        end
                    end else if (!is_power_up(cmd_op)) begin
                        st_nxt   = PS_ACK;
                        tmr_load = 1'b1;
                        tmr_val  = ACK_LD;
                        take_ord = 1'b1;
                    end
                end
            end
            PS_ACK: begin
                if (tmr_done) st_nxt = PS_IDLE;
            end
            PS_PD_FAST: begin
                if (tmr_done) st_nxt = PS_OFF;
            end
            PS_RAMP_DN: begin
                if (tmr_done) st_nxt = PS_OFF;
            end
            default: st_nxt = PS_OFF;
        endcase
    end

    // State register and its companions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= PS_OFF;
            soft_q    <= 1'b0;
            fwd_q     <= 1'b0;
            fwd_op_q  <= '0;
            fwd_arg_q <= '0;
        end else begin
            st_q  <= st_nxt;
            fwd_q <= take_ord;
            if (take_up) soft_q <= (cmd_op == OP_UP_SOFT);
            if (take_ord) begin
                fwd_op_q  <= cmd_op;
                fwd_arg_q <= cmd_arg;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        ncr_n   = 1'b0;
        busy_n  = 1'b0;
        osc_en  = 1'b1;
        ramp_up = 1'b0;
        ramp_dn = 1'b0;
        unique case (st_q)
            PS_OFF: begin
                ncr_n  = 1'b1;
                busy_n = 1'b1;
                osc_en = 1'b0;
            end
            PS_IDLE: begin
                ncr_n  = 1'b1;
                busy_n = !playing;
            end
            PS_ACK:     busy_n  = !playing;
            PS_RAMP_UP: ramp_up = 1'b1;
            PS_RAMP_DN: ramp_dn = 1'b1;
            default: ;
        endcase
    end

    assign cmd_fwd = fwd_q;
    assign fwd_op  = fwd_op_q;
    assign fwd_arg = fwd_arg_q;

    AST_OFF_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !(cmd_valid && is_power_up(cmd_op))) |=> !osc_en) // R2
        else $error("left power-down without a power-up opcode");

    AST_UP_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && cmd_valid && is_power_up(cmd_op)) |=> (!ncr_n && !busy_n && osc_en)) // R3
        else $error("power-up not entered");

    AST_PDN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_IDLE && playing && !(cmd_valid && !is_power_down(cmd_op) && !is_power_up(cmd_op))) |=> (st_q == PS_IDLE)) // R7
        else $error("left idle while playing");

    AST_STAB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_STAB && !tmr_done) |=> (st_q == PS_STAB)) // R8
        else $error("stabilisation cut short");

    AST_FWD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fwd |=> !cmd_fwd) // R9
        else $error("forward pulse longer than one cycle");

    AST_RAMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_up && ramp_dn)) // R6
        else $error("both ramps requested");

endmodule

// File: tb/sim_pwr_cmd_ctrl.sv
module sim_pwr_cmd_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int P_STAB = 20;
    localparam int P_RAMP = 40;
    localparam int P_PDF  = 4;
    localparam int P_ACK  = 3;
    localparam int NV     = 10;

    // op, arg, expected low cycles, ramp cycles, bank after, osc after, forwarded
    localparam int T_OP  [NV] = '{2, 5, 0, 1, 10, 3, 1, 2, 1, 0};
    localparam int T_ARG [NV] = '{0, 0, 2, 1, 5,  0, 3, 0, 1, 0};
    localparam int T_LOW [NV] = '{0, 0, P_STAB, 0, P_ACK, P_RAMP, P_STAB+P_RAMP, P_PDF, P_STAB+P_RAMP, 0};
    localparam int T_RMP [NV] = '{0, 0, 0, 0, 0, P_RAMP, P_RAMP, 0, P_RAMP, 0};
    localparam int T_BNK [NV] = '{0, 0, 2, 2, 2, 2, 0, 0, 1, 1};
    localparam int T_OSC [NV] = '{0, 0, 1, 1, 1, 0, 1, 0, 1, 1};
    localparam int T_FWD [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [3:0] cmd_arg = '0;
    logic       playing = 1'b0;
    logic       ncr_n, busy_n, osc_en, ramp_up, ramp_dn, cmd_fwd;
    logic [1:0] bank_mode;
    logic [3:0] fwd_op, fwd_arg;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_cmd_ctrl #(
        .STAB_CYC(P_STAB), .RAMP_CYC(P_RAMP), .PDF_CYC(P_PDF), .ACK_CYC(P_ACK)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .playing(playing), .ncr_n(ncr_n), .busy_n(busy_n),
        .osc_en(osc_en), .ramp_up(ramp_up), .ramp_dn(ramp_dn),
        .bank_mode(bank_mode), .cmd_fwd(cmd_fwd), .fwd_op(fwd_op), .fwd_arg(fwd_arg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one command at a falling edge; count cycles with ncr_n low.
    // Optionally inject a second command inside that low window.
    task automatic run_cmd(input int op, input int arg, input int inj_at,
                           input int inj_op, output int low, output int rmp,
                           output int fwd, output int busy_low);
        cmd_valid = 1'b1;
        cmd_op    = 4'(op);
        cmd_arg   = 4'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
        low = 0; rmp = 0; busy_low = 0;
        fwd = int'(cmd_fwd);
        while (!ncr_n && low < 1000) begin
            low++;
            if (ramp_up || ramp_dn) rmp++;
            if (!busy_n) busy_low++;
            if (inj_at != 0 && low == inj_at) begin
                cmd_valid = 1'b1;
                cmd_op    = 4'(inj_op);
                cmd_arg   = 4'd3;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int low, rmp, fwd, bl;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ncr_n && busy_n && !osc_en && !ramp_up && !ramp_dn && !cmd_fwd,
            "R1", "outputs in reset", {ncr_n, busy_n, osc_en}, 3'b110);
        chk(bank_mode == 2'b00, "R1", "bank in reset", bank_mode, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ncr_n && busy_n && !osc_en, "R1", "after release", {ncr_n, busy_n, osc_en}, 3'b110);

        // Vector table: R2 R3 R4 R5 R6 R9 R10 R12
        for (int i = 0; i < NV; i++) begin
            run_cmd(T_OP[i], T_ARG[i], 0, 0, low, rmp, fwd, bl);
            chk(low == T_LOW[i], "R2/R3/R4/R5/R6/R9/R12", "ncr low cycles", low, T_LOW[i]);
            chk(rmp == T_RMP[i], "R4/R6", "ramp cycles", rmp, T_RMP[i]);
            chk(int'(bank_mode) == T_BNK[i], "R10", "bank mode", bank_mode, T_BNK[i]);
            chk(int'(osc_en) == T_OSC[i], "R3/R5", "osc after", osc_en, T_OSC[i]);
            chk(fwd == T_FWD[i], "R9", "forward pulse", fwd, T_FWD[i]);
            if (T_OP[i] <= 3 && T_LOW[i] > 0)
                chk(bl == T_LOW[i], "R3/R4/R5/R6", "busy low cycles", bl, T_LOW[i]);
            if (T_FWD[i] == 1)
                chk(fwd_op == 4'(T_OP[i]) && fwd_arg == 4'(T_ARG[i]), "R9",
                    "forward payload", {fwd_op, fwd_arg}, (T_OP[i] << 4) | T_ARG[i]);
        end

        // R13 busy follows playing in idle
        playing = 1'b1;
        @(negedge clk);
        chk(!busy_n && ncr_n, "R13", "busy while playing", busy_n, 0);
        // R7 power-down refused while playing
        run_cmd(2, 0, 0, 0, low, rmp, fwd, bl);
        chk(low == 0 && osc_en, "R7", "fast down while playing", low, 0);
        run_cmd(3, 0, 0, 0, low, rmp, fwd, bl);
        chk(low == 0 && osc_en, "R7", "soft down while playing", low, 0);
        // R9 ordinary command still taken while playing
        run_cmd(6, 9, 0, 0, low, rmp, fwd, bl);
        chk(low == P_ACK && fwd == 1, "R9", "ack while playing", low, P_ACK);
        chk(bl == P_ACK, "R13", "busy low through ack", bl, P_ACK);
        playing = 1'b0;
        @(negedge clk);
        chk(busy_n, "R13", "busy released", busy_n, 1);

        // R8 commands inside timed windows are dropped
        run_cmd(4, 1, 1, 2, low, rmp, fwd, bl);
        chk(low == P_ACK && osc_en, "R8", "down during ack", low, P_ACK);
        run_cmd(3, 0, 10, 0, low, rmp, fwd, bl);
        chk(low == P_RAMP && !osc_en, "R8", "up during ramp down", low, P_RAMP);
        chk(bank_mode == 2'b01, "R10", "bank kept over dropped up", bank_mode, 1);
        run_cmd(1, 2, 5, 2, low, rmp, fwd, bl);
        chk(low == P_STAB + P_RAMP && osc_en, "R8", "down during stab", low, P_STAB + P_RAMP);
        chk(bank_mode == 2'b10, "R10", "bank four", bank_mode, 2);
        run_cmd(2, 0, 0, 0, low, rmp, fwd, bl);
        chk(low == P_PDF && !osc_en, "R5", "fast down", low, P_PDF);
        run_cmd(0, 1, 3, 3, low, rmp, fwd, bl);
        chk(low == P_STAB && osc_en, "R8", "down during fast stab", low, P_STAB);
        chk(bank_mode == 2'b01, "R10", "bank two", bank_mode, 1);
        run_cmd(1, 0, P_STAB + 7, 5, low, rmp, fwd, bl);
        chk(low == 0, "R12", "soft up in idle", low, 0);

        // R11 reset in the middle of a falling ramp
        cmd_valid = 1'b1; cmd_op = 4'd3; cmd_arg = 4'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(ramp_dn && !ncr_n, "R6", "ramp down active", ramp_dn, 1);
        rst_n = 1'b0;
        #1;
        chk(ncr_n && busy_n && !osc_en && !ramp_dn, "R11", "forced off",
            {ncr_n, busy_n, osc_en, ramp_dn}, 4'b1100);
        chk(bank_mode == 2'b00, "R11", "bank cleared", bank_mode, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_cmd(7, 0, 0, 0, low, rmp, fwd, bl);
        chk(low == 0 && !osc_en && fwd == 0, "R2", "ordinary after reset", low, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule